// File: doc/BRIEF.md
# Address Generator with Register Writeback

This block forms the effective address of a load or store as base plus four times an index plus a sign-extended immediate. The result is used as the memory address, and it can also be saved to a register. In no-update form only the access address is produced. In pre-modify form the new address is used for the access and is written back. In post-modify form the access uses the old base register value, and the base register receives the new address. Post-modify therefore delivers two values, the access address and the writeback data.

Only one writeback port is available. A load already uses that port for its own result, so the restricted build (parameter `RESTRICT_LOAD_WB`) allows address writeback only for stores. In the restricted build a load that asks for an update form raises an illegal flag and drops the writeback. Where the base-plus-scaled-index sum has zeros in every bit the offset can reach, the offset may be merged by OR instead of by a carry chain. The block reports which path it used. All results are registered and appear one cycle after the request, qualified by a valid output.

Top module: `agu_wb_top`

## Requirements
- R1: A request accepted with `req_valid_i` high at a rising edge produces `valid_o` high in the following cycle, and `valid_o` is low otherwise. The effective address EA is `base_i + (index_i << 2) + sext(offset_i)`, taken modulo 2^32.
- R2: For mode 0 (no update), `addr_o` equals EA and `wb_en_o` is low.
- R3: For mode 1 (pre-modify) with a permitted writeback, `addr_o` and `wb_data_o` both equal EA, `wb_en_o` is high and `wb_idx_o` equals the requested `wb_reg_i`.
- R4: For mode 2 (post-modify) with a permitted writeback, `addr_o` equals the old `base_i`, `wb_data_o` equals EA, `wb_en_o` is high and `wb_idx_o` equals `wb_reg_i`.
- R5: With `RESTRICT_LOAD_WB`=1, a load (`is_store_i`=0) in mode 1 or 2 sets `illegal_o`, keeps `wb_en_o` low and still drives `addr_o` as that mode defines.
- R6: With `RESTRICT_LOAD_WB`=0, loads in mode 1 or 2 write back exactly as stores do, and `illegal_o` stays low.
- R7: A store never raises `illegal_o` in modes 0 to 2.
- R8: `used_or_o` is high exactly when `or_en_i` is 1, the offset sign bit is 0, and bits [OFF_W-2:0] of the base-plus-scaled-index sum are all zero. In every case `addr_o` keeps the value that R2 to R4 give.
- R9: Mode 3 is reserved. It sets `illegal_o`, keeps `wb_en_o` low and drives `addr_o` with EA.
- R10: While `rst_ni` is low, `valid_o`, `wb_en_o`, `illegal_o` and `used_or_o` are low.
- R11: Whenever `valid_o` is low, `wb_en_o` and `illegal_o` are low, and `wb_idx_o` and `wb_data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| mode_i | input | 2 | 0 none, 1 pre-modify, 2 post-modify, 3 reserved |
| is_store_i | input | 1 | 1 for store, 0 for load |
| or_en_i | input | 1 | Permit OR merging of the offset |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| offset_i | input | 12 | Signed immediate offset |
| wb_reg_i | input | 5 | Register that receives the address |
| valid_o | output | 1 | Results valid |
| addr_o | output | 32 | Memory access address |
| wb_en_o | output | 1 | Address writeback enable |
| wb_idx_o | output | 5 | Address writeback register |
| wb_data_o | output | 32 | Address writeback data |
| illegal_o | output | 1 | Illegal mode or operation combination |
| used_or_o | output | 1 | Offset merged by OR |

## Verification
Every output belongs to the request sampled at the previous rising edge, so all results are due exactly one cycle after the stimulus. The bench changes inputs on the falling edge and compares outputs on the next falling edge, half a cycle after the register update, against a model in the bench. The restricted and unrestricted builds run side by side on the same stimulus, so R5 and R6 are compared on identical requests. Idle cycles between requests check that the outputs fall back to their quiet values.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AM_NONE = 2'd0,
    AM_PRE  = 2'd1,
    AM_POST = 2'd2,
    AM_RSVD = 2'd3
  } agu_mode_e;
endpackage

// File: rtl/agu_ea.sv
module agu_ea #(
  parameter int AW = 32,
  parameter int OFF_W = 12,
  parameter int SCALE_SH = 2
) (
  input  logic [AW-1:0]    base_i,
  input  logic [AW-1:0]    index_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic             or_en_i,
  output logic [AW-1:0]    ea_o,
  output logic             used_or_o
);
  localparam int LOW_W = OFF_W - 1;

  logic [AW-1:0] sum, off_ext;
  logic          low_clear;

  assign sum       = base_i + (index_i << SCALE_SH);
  assign off_ext   = {{(AW-OFF_W){offset_i[OFF_W-1]}}, offset_i};
  // a non-negative offset only reaches bits below its sign bit
  assign low_clear = (sum[LOW_W-1:0] == '0);
  assign used_or_o = or_en_i && !offset_i[OFF_W-1] && low_clear;
  assign ea_o      = used_or_o ? (sum | off_ext) : (sum + off_ext);
endmodule

// File: rtl/agu_wb_arb.sv
module agu_wb_arb
  import agu_pkg::*;
#(
  parameter int AW = 32,
  parameter bit RESTRICT_LOAD_WB = 1'b1
) (
  input  logic [1:0]    mode_i,
  input  logic          is_store_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] ea_i,
  output logic [AW-1:0] addr_o,
  output logic          wb_en_o,
  output logic          illegal_o
);
  agu_mode_e mode;
  logic      upd, port_busy;

  assign mode      = agu_mode_e'(mode_i);
  assign upd       = (mode == AM_PRE) || (mode == AM_POST);
  // a load owns the single result port in the restricted build
  assign port_busy = RESTRICT_LOAD_WB && !is_store_i;

  always_comb begin
    addr_o    = ea_i;
    wb_en_o   = 1'b0;
    illegal_o = 1'b0;
    unique case (mode)
      AM_NONE: ;
      AM_PRE:  ;
      AM_POST: addr_o = base_i;
      AM_RSVD: illegal_o = 1'b1;
    endcase
    if (upd) begin
      wb_en_o   = !port_busy;
      illegal_o = port_busy;
    end
  end
endmodule

// File: rtl/agu_out_reg.sv
module agu_out_reg #(
  parameter int AW = 32,
  parameter int RW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wb_en_i,
  input  logic [RW-1:0] wb_idx_i,
  input  logic [AW-1:0] wb_data_i,
  input  logic          illegal_i,
  input  logic          used_or_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic          wb_en_o,
  output logic [RW-1:0] wb_idx_o,
  output logic [AW-1:0] wb_data_o,
  output logic          illegal_o,
  output logic          used_or_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      addr_o    <= '0;
      wb_en_o   <= 1'b0;
      wb_idx_o  <= '0;
      wb_data_o <= '0;
      illegal_o <= 1'b0;
      used_or_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      addr_o    <= valid_i ? addr_i : '0;
      wb_en_o   <= valid_i && wb_en_i;
      wb_idx_o  <= (valid_i && wb_en_i) ? wb_idx_i : '0;
      wb_data_o <= (valid_i && wb_en_i) ? wb_data_i : '0;
      illegal_o <= valid_i && illegal_i;
      used_or_o <= valid_i && used_or_i;
    end
  end
endmodule

// File: rtl/agu_wb_top.sv
module agu_wb_top
  import agu_pkg::*;
#(
  parameter int AW = 32,
  parameter int OFF_W = 12,
  parameter int RW = 5,
  parameter int SCALE_SH = 2,
  parameter bit RESTRICT_LOAD_WB = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       mode_i,
  input  logic             is_store_i,
  input  logic             or_en_i,
  input  logic [AW-1:0]    base_i,
  input  logic [AW-1:0]    index_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [RW-1:0]    wb_reg_i,
  output logic             valid_o,
  output logic [AW-1:0]    addr_o,
  output logic             wb_en_o,
  output logic [RW-1:0]    wb_idx_o,
  output logic [AW-1:0]    wb_data_o,
  output logic             illegal_o,
  output logic             used_or_o
);
  logic [AW-1:0] ea, addr_c;
  logic          used_or_c, wb_en_c, illegal_c;

  agu_ea #(.AW(AW), .OFF_W(OFF_W), .SCALE_SH(SCALE_SH)) u_ea (
    .base_i   (base_i),
    .index_i  (index_i),
    .offset_i (offset_i),
    .or_en_i  (or_en_i),
    .ea_o     (ea),
    .used_or_o(used_or_c)
  );

  agu_wb_arb #(.AW(AW), .RESTRICT_LOAD_WB(RESTRICT_LOAD_WB)) u_arb (
    .mode_i    (mode_i),
    .is_store_i(is_store_i),
    .base_i    (base_i),
    .ea_i      (ea),
    .addr_o    (addr_c),
    .wb_en_o   (wb_en_c),
    .illegal_o (illegal_c)
  );

  agu_out_reg #(.AW(AW), .RW(RW)) u_oreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (req_valid_i),
    .addr_i   (addr_c),
    .wb_en_i  (wb_en_c),
    .wb_idx_i (wb_reg_i),
    .wb_data_i(ea),
    .illegal_i(illegal_c),
    .used_or_i(used_or_c),
    .valid_o  (valid_o),
    .addr_o   (addr_o),
    .wb_en_o  (wb_en_o),
    .wb_idx_o (wb_idx_o),
    .wb_data_o(wb_data_o),
    .illegal_o(illegal_o),
    .used_or_o(used_or_o)
  );
endmodule

// File: rtl/agu_wb_chk.sv
module agu_wb_chk #(
  parameter int AW = 32,
  parameter int RW = 5,
  parameter bit RESTRICT_LOAD_WB = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [1:0]    mode_i,
  input logic          is_store_i,
  input logic [AW-1:0] base_i,
  input logic [RW-1:0] wb_reg_i,
  input logic          valid_o,
  input logic [AW-1:0] addr_o,
  input logic          wb_en_o,
  input logic [RW-1:0] wb_idx_o,
  input logic [AW-1:0] wb_data_o,
  input logic          illegal_o
);
  logic run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  a_r1_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (valid_o == $past(req_valid_i)));

  a_r11_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!wb_en_o && !illegal_o && wb_data_o == '0));

  a_r3_pre_store_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 2'd1 && is_store_i) |=>
      (wb_en_o && wb_data_o == addr_o && wb_idx_o == $past(wb_reg_i)));

  a_r4_post_old_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 2'd2) |=> (addr_o == $past(base_i)));

  a_r5_illegal_no_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wb_en_o);

  a_r9_rsvd_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 2'd3) |=> (illegal_o && !wb_en_o));

  a_r7_store_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && is_store_i && mode_i != 2'd3) |=> !illegal_o);

  a_r2_none_no_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == 2'd0) |=> !wb_en_o);

  a_r10_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !wb_en_o && !illegal_o));

  generate
    if (RESTRICT_LOAD_WB) begin : g_restrict
      a_r5_load_upd_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !is_store_i && (mode_i == 2'd1 || mode_i == 2'd2)) |=>
          (illegal_o && !wb_en_o));
    end else begin : g_free
      a_r6_load_upd_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && (mode_i == 2'd1 || mode_i == 2'd2)) |=> (wb_en_o && !illegal_o));
    end
  endgenerate
endmodule

bind agu_wb_top agu_wb_chk #(.AW(AW), .RW(RW), .RESTRICT_LOAD_WB(RESTRICT_LOAD_WB)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .mode_i     (mode_i),
  .is_store_i (is_store_i),
  .base_i     (base_i),
  .wb_reg_i   (wb_reg_i),
  .valid_o    (valid_o),
  .addr_o     (addr_o),
  .wb_en_o    (wb_en_o),
  .wb_idx_o   (wb_idx_o),
  .wb_data_o  (wb_data_o),
  .illegal_o  (illegal_o)
);

// File: tb/agu_wb_top_tb.sv
module agu_wb_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  mode = '0;
  logic        is_store = 1'b0;
  logic        or_en = 1'b0;
  logic [31:0] base = '0, index = '0;
  logic [11:0] offset = '0;
  logic [4:0]  wb_reg = '0;

  logic        v_a, we_a, il_a, or_a, v_b, we_b, il_b, or_b;
  logic [31:0] ad_a, wd_a, ad_b, wd_b;
  logic [4:0]  wi_a, wi_b;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  agu_wb_top #(.RESTRICT_LOAD_WB(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .mode_i(mode),
    .is_store_i(is_store), .or_en_i(or_en), .base_i(base), .index_i(index),
    .offset_i(offset), .wb_reg_i(wb_reg), .valid_o(v_a), .addr_o(ad_a),
    .wb_en_o(we_a), .wb_idx_o(wi_a), .wb_data_o(wd_a), .illegal_o(il_a),
    .used_or_o(or_a));

  agu_wb_top #(.RESTRICT_LOAD_WB(1'b0)) u_dut_free (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .mode_i(mode),
    .is_store_i(is_store), .or_en_i(or_en), .base_i(base), .index_i(index),
    .offset_i(offset), .wb_reg_i(wb_reg), .valid_o(v_b), .addr_o(ad_b),
    .wb_en_o(we_b), .wb_idx_o(wi_b), .wb_data_o(wd_b), .illegal_o(il_b),
    .used_or_o(or_b));

  function automatic logic [31:0] ref_ea(logic [31:0] b, logic [31:0] i, logic [11:0] o);
    return b + i * 32'd4 + {{20{o[11]}}, o};
  endfunction

  function automatic logic ref_or(logic [31:0] b, logic [31:0] i, logic [11:0] o, logic en);
    logic [31:0] s;
    s = b + i * 32'd4;
    return en && !o[11] && (s[10:0] == 11'd0);
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, compare at next negedge (one register stage)
  task automatic issue(logic [1:0] m, logic st, logic oe, logic [31:0] b,
                       logic [31:0] ix, logic [11:0] o, logic [4:0] r);
    logic [31:0] ea, exp_addr;
    logic        upd, rsvd, ill_a, ill_b, wbe_a, wbe_b;
    req_valid = 1'b1; mode = m; is_store = st; or_en = oe;
    base = b; index = ix; offset = o; wb_reg = r;
    @(negedge clk);
    ea       = ref_ea(b, ix, o);
    exp_addr = (m == 2'd2) ? b : ea;
    upd      = (m == 2'd1) || (m == 2'd2);
    rsvd     = (m == 2'd3);
    ill_a    = rsvd || (upd && !st);
    wbe_a    = upd && st;
    ill_b    = rsvd;
    wbe_b    = upd;
    check("R1", "valid", {31'd0, v_a}, 32'd1);
    check("R1", "valid_free", {31'd0, v_b}, 32'd1);
    check(m == 2'd2 ? "R4" : (m == 2'd1 ? "R3" : (rsvd ? "R9" : "R2")), "addr", ad_a, exp_addr);
    check("R6", "addr_free", ad_b, exp_addr);
    check(upd && !st ? "R5" : "R3", "wb_en", {31'd0, we_a}, {31'd0, wbe_a});
    check(st ? "R7" : "R5", "illegal", {31'd0, il_a}, {31'd0, ill_a});
    check("R6", "wb_en_free", {31'd0, we_b}, {31'd0, wbe_b});
    check("R6", "illegal_free", {31'd0, il_b}, {31'd0, ill_b});
    if (wbe_a) begin
      check(m == 2'd2 ? "R4" : "R3", "wb_data", wd_a, ea);
      check(m == 2'd2 ? "R4" : "R3", "wb_idx", {27'd0, wi_a}, {27'd0, r});
    end
    if (wbe_b) check("R6", "wb_data_free", wd_b, ea);
    check("R8", "used_or", {31'd0, or_a}, {31'd0, ref_or(b, ix, o, oe)});
    req_valid = 1'b0;
  endtask

  task automatic idle_check();
    req_valid = 1'b0;
    @(negedge clk);
    check("R11", "valid_idle", {31'd0, v_a}, 32'd0);
    check("R11", "wb_en_idle", {31'd0, we_a}, 32'd0);
    check("R11", "illegal_idle", {31'd0, il_a}, 32'd0);
    check("R11", "wb_data_idle", wd_a, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    check("R10", "valid_rst", {31'd0, v_a}, 32'd0);
    check("R10", "wb_en_rst", {31'd0, we_a}, 32'd0);
    check("R10", "illegal_rst", {31'd0, il_a}, 32'd0);
    check("R10", "used_or_rst", {31'd0, or_a}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    issue(2'd0, 1'b0, 1'b0, 32'h0000_1000, 32'h10, 12'h004, 5'd1);       // R2
    issue(2'd1, 1'b1, 1'b0, 32'h2000_0000, 32'h3, 12'hFFC, 5'd7);        // R3 negative off
    issue(2'd2, 1'b1, 1'b0, 32'h0000_4000, 32'h8, 12'h010, 5'd9);        // R4
    issue(2'd1, 1'b0, 1'b0, 32'h0000_8000, 32'h1, 12'h020, 5'd3);        // R5 / R6
    issue(2'd2, 1'b0, 1'b0, 32'h0000_8000, 32'h1, 12'h020, 5'd3);        // R5 / R6
    issue(2'd3, 1'b1, 1'b0, 32'h0000_0100, 32'h0, 12'h001, 5'd4);        // R9
    issue(2'd1, 1'b1, 1'b0, 32'hFFFF_FFF0, 32'h8, 12'h000, 5'd5);        // R1 wrap
    issue(2'd0, 1'b1, 1'b1, 32'h0000_1000, 32'h0, 12'h7FF, 5'd2);        // R8 OR taken
    issue(2'd0, 1'b1, 1'b1, 32'h0000_1004, 32'h0, 12'h7FF, 5'd2);        // R8 low bits set
    issue(2'd0, 1'b1, 1'b1, 32'h0000_1000, 32'h0, 12'h800, 5'd2);        // R8 negative off
    issue(2'd0, 1'b1, 1'b0, 32'h0000_1000, 32'h0, 12'h7FF, 5'd2);        // R8 disabled
    idle_check();
    for (int k = 0; k < 400; k++) begin
      logic [31:0] b;
      b = $urandom();
      if (($urandom() % 4) == 0) b = b & 32'hFFFF_F800;
      issue(2'($urandom()), 1'($urandom()), 1'($urandom()), b,
            ($urandom() % 8 == 0) ? 32'd0 : $urandom(), 12'($urandom()), 5'($urandom()));
      if (($urandom() % 5) == 0) idle_check();
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 50000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired before stimulus completed");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule